// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine moves a requested number of bytes between a local sector buffer and system memory. The regions of system memory are listed in a table of 8-byte descriptors that lives in system memory. One start pulse latches the table base, the byte count and the transfer direction. The engine then alternates between two steps. It reads a descriptor over the memory port. It then issues one or more bursts against the region that descriptor names. It stops when the byte count is used up, when the table ends, or when the descriptor pointer has moved one page past the base.

Each descriptor is read as a single 64-bit word and is little-endian. Bits 31:0 hold the physical region address and bits 63:32 hold the size/flags word. Each burst request carries a byte offset into the local buffer, so the buffer side sees the buffer-read or buffer-write strobe and the offset together with the memory request. At the end the engine gives a one-cycle completion pulse. An error flag is raised in the same cycle when the table ran out before the full count was moved.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the engine is idle: mem_req, buf_rd, buf_wr, done and err are all low.
- R2: The table base is taken with its two low bits forced to zero. Every descriptor fetch is a non-write 8-byte request at the current pointer, and the pointer advances by 8 after each fetch. A fetch is the only request during which both buf_rd and buf_wr are low.
- R3: The region length is size-word bits 15:0 with bit 0 cleared. Size-word bits 30:16 have no effect.
- R4: A decoded length of zero describes a region of 65536 bytes.
- R5: When size-word bit 31 is set, no further descriptor is fetched after that region. If the requested count is still not reached, the engine finishes with err high.
- R6: No descriptor is fetched at a pointer 4096 bytes (PAGE_BYTES) or more past the base. Reaching that limit with bytes still owed ends the transfer with err high.
- R7: Each burst is the smallest of three values: the bytes left in the region, the bytes left in the transfer, and MAX_BURST (64). Successive bursts in a region have contiguous addresses.
- R8: With to_mem high, every burst has mem_write=1 and buf_rd=1. With to_mem low, every burst has mem_write=0 and buf_wr=1.
- R9: buf_off during a burst equals the number of bytes already moved in this transfer.
- R10: A request holds its address and length unchanged until mem_ack, and only one request is outstanding at a time.
- R11: done is a single-cycle pulse, and err is high only together with done. A byte count of zero completes with no memory request and no error.
- R12: A start pulse while a transfer is running has no effect.
- R13: A new start discards any unfinished region from the previous transfer and fetches a fresh descriptor from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| table_base | input | 32 | Physical address of the descriptor table |
| byte_count | input | CNT_W | Bytes to move |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| mem_req | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a memory write |
| mem_addr | output | 32 | Request byte address |
| mem_bytes | output | 17 | Request length in bytes |
| mem_ack | input | 1 | Request accepted and completed |
| mem_rdata | input | 64 | Descriptor data, valid with mem_ack |
| buf_rd | output | 1 | Buffer is read for this burst |
| buf_wr | output | 1 | Buffer is written for this burst |
| buf_off | output | CNT_W | Buffer byte offset of this burst |
| done | output | 1 | Transfer finished (one cycle) |
| err | output | 1 | Table ended before the count was reached |

## Verification
A wrong region length or a wrong end-of-table flag appears at the ports right away. The burst length or address of the very next request is wrong, or an extra descriptor fetch appears where none is due. A stale descriptor pointer shows up as the address of the following fetch. A corrupted remaining-byte counter shows up in the last burst's length and in the value of err at the done pulse. So every internal fault is visible within one request cycle, or at latest at completion. Comparing fetch counts, burst lengths, offsets and addresses per transfer pins it down.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int PHYS_W   = 32;
   localparam int REGION_W = 17;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_FETCH,
      ST_XFER,
      ST_FIN
   } sgd_state_e;

   typedef struct packed {
      logic [PHYS_W-1:0]   addr;
      logic [REGION_W-1:0] len;
      logic                last;
   } sgd_region_t;
endpackage

// File: rtl/sgd_desc_decode.sv
module sgd_desc_decode
   import sgd_pkg::*;
(
   input  logic [63:0]  raw,
   output sgd_region_t  region
);
   logic [15:0] len16;
   logic        unused_flag_bits;

   always_comb begin
      len16            = raw[47:32] & 16'hFFFE;
      region.addr      = raw[31:0];
      region.len       = (len16 == 16'd0) ? REGION_W'(17'h10000) : {1'b0, len16};
      region.last      = raw[63];
      unused_flag_bits = ^raw[62:48];
   end
endmodule

// File: rtl/sgd_burst_calc.sv
module sgd_burst_calc
   import sgd_pkg::*;
#(
   parameter int CNT_W     = 24,
   parameter int MAX_BURST = 64,
   parameter bit SPLIT     = 1'b1
) (
   input  logic [REGION_W-1:0] region_left,
   input  logic [CNT_W-1:0]    bytes_left,
   output logic [REGION_W-1:0] burst
);
   logic [CNT_W-1:0] rgn_ext;
   logic [CNT_W-1:0] smaller;

   always_comb begin
      rgn_ext = CNT_W'(region_left);
      smaller = (rgn_ext < bytes_left) ? rgn_ext : bytes_left;
   end

   generate
      if (SPLIT) begin : g_capped
         always_comb
            burst = (smaller > CNT_W'(MAX_BURST)) ? REGION_W'(MAX_BURST)
                                                   : smaller[REGION_W-1:0];
      end else begin : g_whole
         always_comb burst = smaller[REGION_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
   import sgd_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int MAX_BURST  = 64,
   parameter bit SPLIT      = 1'b1,
   parameter int PAGE_BYTES = 4096
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PHYS_W-1:0]   table_base,
   input  logic [CNT_W-1:0]    byte_count,
   input  logic                to_mem,
   output logic                mem_req,
   output logic                mem_write,
   output logic [PHYS_W-1:0]   mem_addr,
   output logic [REGION_W-1:0] mem_bytes,
   input  logic                mem_ack,
   input  logic [63:0]         mem_rdata,
   output logic                buf_rd,
   output logic                buf_wr,
   output logic [CNT_W-1:0]    buf_off,
   output logic                done,
   output logic                err
);
   localparam logic [PHYS_W-1:0]   DESC_STEP = PHYS_W'(8);
   localparam logic [PHYS_W-1:0]   PAGE_LIM  = PHYS_W'(PAGE_BYTES);
   localparam logic [REGION_W-1:0] DESC_LEN  = REGION_W'(8);

   generate
      if (CNT_W < REGION_W) begin : g_bad_cnt_w
         $error("CNT_W must hold at least one full region");
      end
      if (MAX_BURST < 2 || MAX_BURST > 65536) begin : g_bad_burst
         $error("MAX_BURST out of range");
      end
      if (PAGE_BYTES < 8 || (PAGE_BYTES % 8) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a positive multiple of 8");
      end
   endgenerate

   sgd_state_e            state;
   logic [PHYS_W-1:0]     base_q, ptr_q, rgn_addr;
   logic [REGION_W-1:0]   rgn_len, burst;
   logic                  rgn_last, dir_q, err_q;
   logic [CNT_W-1:0]      left_q, off_q;
   logic                  page_full;
   sgd_region_t           dec;

   sgd_desc_decode u_dec (.raw(mem_rdata), .region(dec));

   sgd_burst_calc #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .SPLIT(SPLIT)) u_burst (
      .region_left(rgn_len),
      .bytes_left (left_q),
      .burst      (burst)
   );

   assign page_full = (ptr_q - base_q) >= PAGE_LIM;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         base_q   <= '0;
         ptr_q    <= '0;
         rgn_addr <= '0;
         rgn_len  <= '0;
         rgn_last <= 1'b0;
         left_q   <= '0;
         off_q    <= '0;
         dir_q    <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               base_q   <= table_base & ~PHYS_W'(3);
               ptr_q    <= table_base & ~PHYS_W'(3);
               rgn_addr <= '0;
               rgn_len  <= '0;
               rgn_last <= 1'b0;
               left_q   <= byte_count;
               off_q    <= '0;
               dir_q    <= to_mem;
               err_q    <= 1'b0;
               state    <= ST_DECIDE;
            end
            ST_DECIDE: begin
               if (left_q == '0) begin
                  state <= ST_FIN;
               end else if (rgn_len != '0) begin
                  state <= ST_XFER;
               end else if (rgn_last || page_full) begin
                  err_q <= 1'b1;
                  state <= ST_FIN;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_ack) begin
               rgn_addr <= dec.addr;
               rgn_len  <= dec.len;
               rgn_last <= dec.last;
               ptr_q    <= ptr_q + DESC_STEP;
               state    <= ST_DECIDE;
            end
            ST_XFER: if (mem_ack) begin
               rgn_addr <= rgn_addr + PHYS_W'(burst);
               rgn_len  <= rgn_len - burst;
               left_q   <= left_q - CNT_W'(burst);
               off_q    <= off_q + CNT_W'(burst);
               state    <= ST_DECIDE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == ST_FETCH) || (state == ST_XFER);
      mem_write = (state == ST_XFER) && dir_q;
      mem_addr  = (state == ST_FETCH) ? ptr_q : rgn_addr;
      mem_bytes = (state == ST_FETCH) ? DESC_LEN : burst;
      buf_rd    = (state == ST_XFER) && dir_q;
      buf_wr    = (state == ST_XFER) && !dir_q;
      buf_off   = off_q;
      done      = (state == ST_FIN);
      err       = (state == ST_FIN) && err_q;
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_bytes)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R6
   page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !buf_rd && !buf_wr) |-> ((mem_addr - base_q) < PAGE_LIM));

   // R7
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd || buf_wr) |-> (mem_bytes != '0 && mem_bytes <= rgn_len &&
                              CNT_W'(mem_bytes) <= left_q &&
                              (!SPLIT || mem_bytes <= REGION_W'(MAX_BURST))));

   // R8
   dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd || buf_wr) |-> (mem_write == buf_rd && $onehot0({buf_rd, buf_wr})));

   // R12
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE) |=> $stable(base_q));
endmodule

// File: tb/tb_sg_dma_engine.sv
module tb_sg_dma_engine;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 24;
   localparam logic [31:0] TBASE = 32'h0000_8000;
   localparam logic [31:0] A0 = 32'h1000_0000;
   localparam logic [31:0] A1 = 32'h2000_0000;
   localparam logic [31:0] A2 = 32'h3000_0000;
   localparam int NDESC = 520;

   typedef struct packed {
      logic [31:0] s0, s1, s2;
      logic [23:0] cnt;
      logic        dir;
      logic [15:0] fet, bur, byt;
      logic        er;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'h8000_0064, 32'h0, 32'h0, 24'd100, 1'b1, 16'd1, 16'd2, 16'd100, 1'b0},
      '{32'h0000_0028, 32'h8000_001E, 32'h0, 24'd70, 1'b0, 16'd2, 16'd2, 16'd70, 1'b0},
      '{32'h8000_0065, 32'h0, 32'h0, 24'd200, 1'b1, 16'd1, 16'd2, 16'd100, 1'b1},
      '{32'h8000_0000, 32'h0, 32'h0, 24'd130, 1'b0, 16'd1, 16'd3, 16'd130, 1'b0},
      '{32'h0000_0032, 32'h8000_0032, 32'h0, 24'd30, 1'b1, 16'd1, 16'd1, 16'd30, 1'b0},
      '{32'h8000_0010, 32'h0, 32'h0, 24'd0, 1'b0, 16'd0, 16'd0, 16'd0, 1'b0},
      '{32'h0000_000A, 32'h0000_000A, 32'h8000_000A, 24'd25, 1'b0, 16'd3, 16'd3, 16'd25, 1'b0},
      '{32'h8001_0003, 32'h0, 32'h0, 24'd10, 1'b1, 16'd1, 16'd1, 16'd2, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [31:0]       table_base = '0;
   logic [CNT_W-1:0]  byte_count = '0;
   logic              to_mem = 1'b0;
   logic              mem_req, mem_write, mem_ack = 1'b0;
   logic [31:0]       mem_addr;
   logic [16:0]       mem_bytes;
   logic [63:0]       mem_rdata = '0;
   logic              buf_rd, buf_wr, done, err;
   logic [CNT_W-1:0]  buf_off;

   sg_dma_engine #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
      .byte_count(byte_count), .to_mem(to_mem), .mem_req(mem_req),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr),
      .buf_off(buf_off), .done(done), .err(err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [63:0] dmem [NDESC];
   int n_checks = 0, n_fail = 0;
   int n_fetch, n_burst, tot_bytes, bad_dir, bad_off, bad_hold, done_seen, wait_cnt;
   logic err_seen, cur_dir, finished = 1'b0;
   logic [31:0] fetch_addr [4];
   logic [31:0] burst_addr [8];
   int          burst_len  [8];
   logic [31:0] prev_addr;
   logic        prev_pending = 1'b0;

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lookup(input logic [31:0] a);
      logic [31:0] idx;
      idx = (a - TBASE) >> 3;
      return (idx < NDESC) ? dmem[idx] : 64'h0;
   endfunction

   // memory responder and port monitor, active on the falling edge
   always @(negedge clk) begin
      if (done) begin
         done_seen++;
         err_seen = err;
      end
      if (mem_req && !mem_ack && prev_pending && mem_addr != prev_addr) bad_hold++;
      if (mem_ack) begin
         mem_ack = 1'b0;
         prev_pending = 1'b0;
      end else if (mem_req) begin
         prev_pending = 1'b1;
         prev_addr = mem_addr;
         if (wait_cnt == 1) begin
            wait_cnt = 0;
            mem_ack = 1'b1;
            mem_rdata = lookup(mem_addr);
            if (!buf_rd && !buf_wr) begin
               if (n_fetch < 4) fetch_addr[n_fetch] = mem_addr;
               n_fetch++;
            end else begin
               if (n_burst < 8) begin
                  burst_addr[n_burst] = mem_addr;
                  burst_len[n_burst]  = int'(mem_bytes);
               end
               if (mem_write != cur_dir || buf_rd != cur_dir || buf_wr == cur_dir) bad_dir++;
               if (int'(buf_off) != tot_bytes) bad_off++;
               tot_bytes += int'(mem_bytes);
               n_burst++;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic clear_logs();
      n_fetch = 0; n_burst = 0; tot_bytes = 0; bad_dir = 0; bad_off = 0;
      done_seen = 0; err_seen = 1'b0; wait_cnt = 0;
      for (int i = 0; i < 4; i++) fetch_addr[i] = '0;
      for (int i = 0; i < 8; i++) begin burst_addr[i] = '0; burst_len[i] = 0; end
   endtask

   task automatic load_table(input logic [31:0] s0, input logic [31:0] s1, input logic [31:0] s2);
      for (int i = 0; i < NDESC; i++) dmem[i] = {32'h8000_0002, 32'h4000_0000};
      dmem[0] = {s0, A0};
      dmem[1] = {s1, A1};
      dmem[2] = {s2, A2};
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000 && done_seen == 0; i++) begin
         @(negedge clk); #1;
      end
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic run(input logic [31:0] base, input int cnt, input logic dir);
      @(negedge clk); #1;
      clear_logs();
      cur_dir = dir;
      table_base = base; byte_count = CNT_W'(cnt); to_mem = dir; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      wait_done();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      clear_logs();
      bad_hold = 0;
      cur_dir = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 mem_req", mem_req, 0);
      check("R1 done", done, 0);
      check("R1 err", err, 0);
      check("R1 buf strobes", {buf_rd, buf_wr}, 0);
      rst_n = 1'b1;

      foreach (VECS[v]) begin
         load_table(VECS[v].s0, VECS[v].s1, VECS[v].s2);
         run(TBASE, int'(VECS[v].cnt), VECS[v].dir);
         check($sformatf("R2 R5 vec%0d fetches", v), n_fetch, VECS[v].fet);
         check($sformatf("R7 vec%0d bursts", v), n_burst, VECS[v].bur);
         check($sformatf("R3 R4 vec%0d bytes", v), tot_bytes, VECS[v].byt);
         check($sformatf("R5 vec%0d err", v), err_seen, VECS[v].er);
         check($sformatf("R11 vec%0d done pulses", v), done_seen, 1);
         check($sformatf("R8 vec%0d direction", v), bad_dir, 0);
         check($sformatf("R9 vec%0d buffer offset", v), bad_off, 0);
      end

      // R7 burst split and contiguous addresses
      load_table(32'h8000_0064, 32'h0, 32'h0);
      run(TBASE, 100, 1'b1);
      check("R7 first burst len", burst_len[0], 64);
      check("R7 second burst len", burst_len[1], 36);
      check("R7 second burst addr", burst_addr[1], A0 + 32'd64);
      check("R2 first fetch addr", fetch_addr[0], TBASE);

      // R2 base alignment and pointer step
      load_table(32'h0000_0028, 32'h8000_001E, 32'h0);
      run(TBASE + 32'd3, 70, 1'b0);
      check("R2 aligned fetch addr", fetch_addr[0], TBASE);
      check("R2 pointer step", fetch_addr[1], TBASE + 32'd8);
      check("R2 second region addr", burst_addr[1], A1);

      // R4 64 KiB region
      load_table(32'h8000_0000, 32'h0, 32'h0);
      run(TBASE, 130, 1'b0);
      check("R4 third burst addr", burst_addr[2], A0 + 32'd128);
      check("R4 third burst len", burst_len[2], 2);

      // R13 leftover region discarded by a new start
      load_table(32'h0000_0032, 32'h8000_0032, 32'h0);
      run(TBASE, 30, 1'b1);
      run(TBASE, 10, 1'b1);
      check("R13 fresh fetch", n_fetch, 1);
      check("R13 restart addr", burst_addr[0], A0);

      // R6 one page of descriptors
      for (int i = 0; i < NDESC; i++) dmem[i] = {32'h0000_0002, 32'h5000_0000 + 32'(i * 16)};
      for (int i = 512; i < NDESC; i++) dmem[i] = {32'h8000_0100, 32'h6000_0000};
      run(TBASE, 5000, 1'b0);
      check("R6 fetch count", n_fetch, 512);
      check("R6 bytes moved", tot_bytes, 1024);
      check("R6 err", err_seen, 1);

      // R12 start while busy
      load_table(32'h8000_0064, 32'h0, 32'h0);
      @(negedge clk); #1;
      clear_logs();
      cur_dir = 1'b1;
      table_base = TBASE; byte_count = CNT_W'(100); to_mem = 1'b1; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      table_base = 32'h0000_9000; byte_count = CNT_W'(2); to_mem = 1'b0; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      wait_done();
      check("R12 fetches", n_fetch, 1);
      check("R12 bytes", tot_bytes, 100);
      check("R12 fetch addr", fetch_addr[0], TBASE);
      check("R12 direction kept", bad_dir, 0);

      // R10 request held until acknowledged
      check("R10 request hold", bad_hold, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule